// File: doc/BRIEF.md
# Serial Pattern Generator Channel

This block is one channel of a programmable serial pattern source. It drives a serial data line together with a matching serial clock line. It shifts a seed word of 1 to 64 bits out least significant bit first and sends that word a programmed number of times, back to back. The serial clock comes from the system clock through a wide half-period divider. A polarity select chooses which serial clock edge moves the data.

Software, or a surrounding controller, programs the seed, the length, the repeat count, the divider and the polarity, then raises `enable`. The block copies every setting on the cycle it starts. Any change to the inputs after that point is ignored until the run ends. When the last bit has been sent, a one-cycle `run_done` pulse marks the end. The channel then stays quiet until `enable` is lowered and raised again.

Top module: `serpat_channel`

## Requirements
- R1: While reset is asserted, `ser_clk` is 1, `ser_data` is 0 and `run_done` is 0.
- R2: While `enable` is low, `ser_clk` equals the inverse of `cfg_pol` (its idle level) one cycle later, `ser_data` is 0 and `run_done` is 0.
- R3: A run starts at the first clock edge at which `enable` is high while the channel is idle. From that edge on, `ser_clk` toggles every `cfg_div`+1 system cycles, and the first toggle comes `cfg_div`+1 cycles after the start edge. A `cfg_div` of 0 gives half the system clock rate.
- R4: Seed bits are sent least significant bit first. The k-th bit of a pass (k counting from 0) is seed bit k, and `ser_data` carries it from the k-th leading edge of the pass until the next leading edge.
- R5: A pass holds `cfg_len_m1`+1 bits. After bit `cfg_len_m1`, the next leading edge carries seed bit 0 again, with no gap between passes.
- R6: The pattern is sent `cfg_reps_m1`+1 times. The run therefore has exactly 2·(`cfg_len_m1`+1)·(`cfg_reps_m1`+1) serial clock toggles.
- R7: `ser_data` changes only on the edge where `ser_clk` leaves its idle level. With `cfg_pol`=0 this is the falling edge (idle high). With `cfg_pol`=1 it is the rising edge (idle low).
- R8: Changes to `cfg_seed`, `cfg_len_m1`, `cfg_reps_m1`, `cfg_div` and `cfg_pol` while the channel runs have no effect. The values captured at the start edge hold for the whole run.
- R9: `run_done` is a pulse exactly one cycle long. It rises on the same edge as the final toggle, which returns `ser_clk` to idle, and on that edge `ser_data` goes to 0.
- R10: After `run_done`, while `enable` stays high, `ser_clk` rests at the captured idle level, `ser_data` stays 0 and no further `run_done` appears.
- R11: Lowering `enable` during a run aborts it. One cycle later the outputs are at idle (`ser_clk` = inverse of `cfg_pol`, `ser_data` = 0), and the next rise of `enable` starts a fresh run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low returns the channel to idle |
| cfg_seed | input | 64 | Seed pattern, bit 0 sent first |
| cfg_len_m1 | input | 6 | Pattern length minus one |
| cfg_reps_m1 | input | 10 | Pattern repetitions minus one |
| cfg_div | input | 32 | Half-period of the serial clock minus one, in system cycles |
| cfg_pol | input | 1 | 0: data moves on falling edge; 1: data moves on rising edge |
| ser_data | output | 1 | Serial data line |
| ser_clk | output | 1 | Serial clock line |
| run_done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The bench aims at the bit-count corners. A one-bit pattern with one pass tests the `len_m1`/`reps_m1` offsets: a design that treats these fields as plain counts would send an extra bit or an extra pass, and `run_done` would come late. A full 64-bit seed, and a single bit repeated 1024 times, test the wrap of the bit index and the top of the repeat counter: an error there shows up as a gap, a wrong bit after the wrap, or a repeat count that overflows back to one pass. The inputs are scrambled on every cycle of a run. A design that does not latch its settings would then change data, rate or polarity in the middle of a run. An abort in mid-run followed by a restart exposes counters that are not cleared between runs.

// File: rtl/serpat_pkg.sv
package serpat_pkg;

  typedef enum logic [1:0] {
    SP_IDLE = 2'd0,
    SP_RUN  = 2'd1,
    SP_HOLD = 2'd2
  } sp_state_e;

  // Resting level of the serial clock for a given polarity select.
  function automatic logic sp_idle_level(input logic pol);
    return ~pol;
  endfunction

  // Number of bits in a full run from the minus-one fields.
  function automatic int unsigned sp_total_bits(input int unsigned len_m1,
                                                input int unsigned reps_m1);
    return (len_m1 + 32'd1) * (reps_m1 + 32'd1);
  endfunction

  // Number of serial clock toggles in a full run.
  function automatic int unsigned sp_total_toggles(input int unsigned len_m1,
                                                   input int unsigned reps_m1);
    return 32'd2 * sp_total_bits(len_m1, reps_m1);
  endfunction

endpackage

// File: rtl/serpat_halfper.sv
module serpat_halfper #(
  parameter int DIV_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);

  logic [DIV_W-1:0] count_q;

  assign tick = run && (count_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (!run) begin
      count_q <= '0;
    end else if (count_q == limit) begin
      count_q <= '0;
    end else begin
      count_q <= count_q + 1'b1;
    end
  end

  // R3: the half-period counter never passes the captured limit
  assert_count_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (count_q <= limit));

  // R3: counter restarts from zero whenever a run is not active
  assert_count_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count_q == '0));

endmodule

// File: rtl/serpat_bitseq.sv
module serpat_bitseq #(
  parameter int LEN_W = 6,
  parameter int REP_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [LEN_W-1:0] len_m1,
  input  logic [REP_W-1:0] reps_m1,
  output logic [LEN_W-1:0] bit_idx,
  output logic             last_bit
);

  logic [LEN_W-1:0] idx_q;
  logic [REP_W-1:0] rep_q;
  logic             pass_end;

  assign pass_end = (idx_q == len_m1);
  assign last_bit = pass_end && (rep_q == reps_m1);
  assign bit_idx  = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      rep_q <= '0;
    end else if (load) begin
      idx_q <= '0;
      rep_q <= '0;
    end else if (step) begin
      if (pass_end) begin
        idx_q <= '0;
        if (rep_q != reps_m1) begin
          rep_q <= rep_q + 1'b1;
        end
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // R5: the bit index stays inside the programmed pass length
  assert_idx_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |-> (idx_q <= len_m1));

  // R6: the pass counter stays inside the programmed repeat count
  assert_rep_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |-> (rep_q <= reps_m1));

  // R5: a step at the end of a pass that is not the last wraps to bit 0
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && pass_end && !last_bit) |=> (idx_q == '0));

endmodule

// File: rtl/serpat_channel.sv
module serpat_channel
  import serpat_pkg::*;
#(
  parameter int SEED_W = 64,
  parameter int REP_W  = 10,
  parameter int DIV_W  = 32,
  localparam int LEN_W = $clog2(SEED_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [SEED_W-1:0] cfg_seed,
  input  logic [LEN_W-1:0]  cfg_len_m1,
  input  logic [REP_W-1:0]  cfg_reps_m1,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_pol,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              run_done
);

  localparam int EDGE_W = LEN_W + REP_W + 2;

  sp_state_e         st_q;
  logic [SEED_W-1:0] cap_seed;
  logic [LEN_W-1:0]  cap_len;
  logic [REP_W-1:0]  cap_reps;
  logic [DIV_W-1:0]  cap_div;
  logic              cap_pol;
  logic              sclk_q;
  logic              sdat_q;
  logic              done_q;
  logic [EDGE_W-1:0] edge_cnt_q;

  // Named internal events
  logic             running;
  logic             start_evt;
  logic             tick;
  logic             at_idle;
  logic             lead_evt;
  logic             trail_evt;
  logic             final_evt;
  logic [LEN_W-1:0] bit_idx;
  logic             last_bit;
  logic             idle_lvl;

  assign running   = (st_q == SP_RUN);
  assign start_evt = enable && (st_q == SP_IDLE);
  assign idle_lvl  = sp_idle_level(cap_pol);
  assign at_idle   = (sclk_q == idle_lvl);
  assign lead_evt  = enable && running && tick && at_idle;
  assign trail_evt = enable && running && tick && !at_idle;
  assign final_evt = trail_evt && last_bit;

  serpat_halfper #(.DIV_W(DIV_W)) u_halfper (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (running),
    .limit (cap_div),
    .tick  (tick)
  );

  serpat_bitseq #(.LEN_W(LEN_W), .REP_W(REP_W)) u_bitseq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_evt),
    .step     (trail_evt),
    .len_m1   (cap_len),
    .reps_m1  (cap_reps),
    .bit_idx  (bit_idx),
    .last_bit (last_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SP_IDLE;
      cap_seed <= '0;
      cap_len  <= '0;
      cap_reps <= '0;
      cap_div  <= '0;
      cap_pol  <= 1'b0;
      sclk_q   <= 1'b1;
      sdat_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!enable) begin
        st_q   <= SP_IDLE;
        sclk_q <= sp_idle_level(cfg_pol);
        sdat_q <= 1'b0;
      end else begin
        case (st_q)
          SP_IDLE: begin
            st_q     <= SP_RUN;
            cap_seed <= cfg_seed;
            cap_len  <= cfg_len_m1;
            cap_reps <= cfg_reps_m1;
            cap_div  <= cfg_div;
            cap_pol  <= cfg_pol;
            sclk_q   <= sp_idle_level(cfg_pol);
            sdat_q   <= 1'b0;
          end
          SP_RUN: begin
            if (lead_evt) begin
              sclk_q <= ~sclk_q;
              sdat_q <= cap_seed[bit_idx];
            end else if (trail_evt) begin
              sclk_q <= ~sclk_q;
              if (final_evt) begin
                done_q <= 1'b1;
                sdat_q <= 1'b0;
                st_q   <= SP_HOLD;
              end
            end
          end
          SP_HOLD: begin
            sclk_q <= idle_lvl;
            sdat_q <= 1'b0;
          end
          default: st_q <= SP_IDLE;
        endcase
      end
    end
  end

  // Toggle counter over the run, used by the checks below
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_cnt_q <= '0;
    end else if (start_evt) begin
      edge_cnt_q <= '0;
    end else if (lead_evt || trail_evt) begin
      edge_cnt_q <= edge_cnt_q + 1'b1;
    end
  end

  assign ser_data = sdat_q;
  assign ser_clk  = sclk_q;
  assign run_done = done_q;

  // R2 and R11: a low enable returns everything to idle on the next edge
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sdat_q && !done_q && (st_q == SP_IDLE)));

  // R7: data only moves while the serial clock sits at its active level
  assert_data_on_lead_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !$stable(sdat_q)) |-> (sclk_q != idle_lvl));

  // R8: captured settings hold still through a run
  assert_frozen_cfg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(st_q) == SP_RUN) |->
      ($stable(cap_seed) && $stable(cap_len) && $stable(cap_reps) &&
       $stable(cap_div) && $stable(cap_pol)));

  // R9: the done event lasts one cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9: done arrives with the clock back at idle and the data line low
  assert_done_at_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ((sclk_q == idle_lvl) && !sdat_q && (st_q == SP_HOLD)));

  // R6: done follows exactly the programmed number of toggles
  assert_done_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (32'(edge_cnt_q) ==
                sp_total_toggles(32'(cap_len), 32'(cap_reps))));

  // R10: once finished, the channel stays parked while enable is held
  assert_hold_parked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == SP_HOLD) && enable) |=> ((st_q == SP_HOLD) && !done_q));

endmodule

// File: tb/test_serpat_channel.sv
`timescale 1ns/1ps
module test_serpat_channel;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic [63:0] cfg_seed;
  logic [5:0]  cfg_len_m1;
  logic [9:0]  cfg_reps_m1;
  logic [31:0] cfg_div;
  logic        cfg_pol;
  logic        ser_data;
  logic        ser_clk;
  logic        run_done;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  serpat_channel i_serpat_channel (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .cfg_seed    (cfg_seed),
    .cfg_len_m1  (cfg_len_m1),
    .cfg_reps_m1 (cfg_reps_m1),
    .cfg_div     (cfg_div),
    .cfg_pol     (cfg_pol),
    .ser_data    (ser_data),
    .ser_clk     (ser_clk),
    .run_done    (run_done)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Toggles that have happened c edges after the start edge
  function automatic int toggles_at(input int c, input int div, input int n2);
    int t;
    t = c / (div + 1);
    return (t > n2) ? n2 : t;
  endfunction

  function automatic logic exp_clk(input int t, input int n2, input logic pol);
    if (t >= n2) return ~pol;
    return (~pol) ^ t[0];
  endfunction

  function automatic logic exp_data(input int t, input int n2, input int len,
                                    input logic [63:0] s);
    if (t == 0 || t >= n2) return 1'b0;
    return s[((t - 1) / 2) % (len + 1)];
  endfunction

  task automatic scramble();
    cfg_seed    = {$urandom(), $urandom()};
    cfg_len_m1  = 6'($urandom());
    cfg_reps_m1 = 10'($urandom());
    cfg_div     = 32'($urandom() % 5);
    cfg_pol     = 1'($urandom());
  endtask

  task automatic run_case(input logic [63:0] s, input int len, input int reps,
                          input int div, input logic pol, input bit mix);
    int n2;
    int span;
    logic prev_data;
    n2   = 2 * (len + 1) * (reps + 1);
    span = n2 * (div + 1);
    @(negedge clk);
    cfg_seed = s; cfg_len_m1 = 6'(len); cfg_reps_m1 = 10'(reps);
    cfg_div = 32'(div); cfg_pol = pol;
    @(negedge clk);
    chk(ser_clk == ~pol, "R2 idle clock", ser_clk, ~pol);
    chk(ser_data == 1'b0, "R2 idle data", ser_data, 0);
    enable = 1'b1;
    prev_data = 1'b0;
    for (int c = 0; c <= span + 6; c++) begin
      int t;
      @(negedge clk);
      t = toggles_at(c, div, n2);
      if (c > span) begin
        chk(ser_clk == ~pol, "R10 parked clock", ser_clk, ~pol);
        chk(ser_data == 1'b0, "R10 parked data", ser_data, 0);
        chk(run_done == 1'b0, "R10 no second done", run_done, 0);
      end else begin
        chk(ser_clk == exp_clk(t, n2, pol), mix ? "R8 clock frozen" : "R3 clock timing",
            ser_clk, exp_clk(t, n2, pol));
        if (t > 2 && ((t - 1) / 2) % (len + 1) == 0 && t < n2)
          chk(ser_data == exp_data(t, n2, len, s), "R5 pass wrap",
              ser_data, exp_data(t, n2, len, s));
        else
          chk(ser_data == exp_data(t, n2, len, s), mix ? "R8 data frozen" : "R4 data order",
              ser_data, exp_data(t, n2, len, s));
        if (ser_data != prev_data && c != span)
          chk(ser_clk == pol, "R7 data moves on leading edge", ser_clk, pol);
        if (c == span)
          chk(run_done == 1'b1, "R6 done after all passes", run_done, 1);
        else
          chk(run_done == 1'b0, "R9 done single cycle", run_done, 0);
      end
      prev_data = ser_data;
      if (mix) scramble();
    end
    enable = 1'b0;
    @(negedge clk);
    chk(ser_clk == ~cfg_pol, "R2 back to idle clock", ser_clk, ~cfg_pol);
    chk(ser_data == 1'b0, "R2 back to idle data", ser_data, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 1'b0; enable = 1'b0;
    cfg_seed = '0; cfg_len_m1 = '0; cfg_reps_m1 = '0; cfg_div = '0; cfg_pol = 1'b0;
    repeat (3) @(negedge clk);
    chk(ser_clk == 1'b1, "R1 reset clock", ser_clk, 1);
    chk(ser_data == 1'b0, "R1 reset data", ser_data, 0);
    chk(run_done == 1'b0, "R1 reset done", run_done, 0);
    rst_n = 1'b1;

    // Directed corners
    run_case(64'h1, 0, 0, 0, 1'b0, 1'b0);
    run_case(64'hA5C3_0F96_7E18_D24B, 63, 0, 1, 1'b1, 1'b0);
    run_case(64'h1, 0, 1023, 0, 1'b1, 1'b0);
    run_case(64'h0000_0000_0000_00B6, 7, 2, 37, 1'b0, 1'b0);
    run_case(64'h8000_0000_0000_0001, 63, 1, 0, 1'b0, 1'b1);

    // Abort in mid-run, then a fresh run
    @(negedge clk);
    cfg_seed = 64'hFFFF_FFFF_FFFF_FFFF; cfg_len_m1 = 6'd63; cfg_reps_m1 = 10'd3;
    cfg_div = 32'd2; cfg_pol = 1'b1;
    enable = 1'b1;
    repeat (20) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(ser_clk == ~cfg_pol, "R11 abort clock idle", ser_clk, ~cfg_pol);
    chk(ser_data == 1'b0, "R11 abort data low", ser_data, 0);
    chk(run_done == 1'b0, "R11 abort no done", run_done, 0);
    run_case(64'h3, 1, 1, 0, 1'b1, 1'b0);

    // Random runs with inputs scrambled during each run
    for (int k = 0; k < 12; k++) begin
      run_case({$urandom(), $urandom()}, int'($urandom() % 64), int'($urandom() % 4),
               int'($urandom() % 4), 1'($urandom()), 1'b1);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule